// File: doc/BRIEF.md
# Per-Slot Bimodal Direction Predictor

This block gives a taken/not-taken guess for every instruction slot of an aligned four-instruction fetch group, all in the same cycle. Each guess comes from a two-bit saturating counter. The counters are stored in one bank per slot, so each bank needs only one read port. A bank is addressed by the low address bits that lie above the slot field. Entries carry no tag. Any two branches that share those low bits therefore share one counter and disturb each other.

The fetch stage presents the group's line index each cycle. The registered predictions appear on the next cycle. When a branch resolves, the back end presents its address bits and actual direction on the update port. The counter for that branch then moves one step toward the direction that actually occurred, and stops at either end of its range. The caller slices the addresses before they reach the block: `fetch_line` carries address bits [IDX_W+3:4], and `upd_pc` carries address bits [IDX_W+3:2]. Bits above these are never examined.

Top module: `bp_slot_predictor`

## Requirements
- R1: A synchronous reset loads every counter with weakly-not-taken (01) and clears `pred_taken`. A single taken update to one entry then makes that entry predict taken.
- R2: `pred_taken[s]` is the most significant bit of slot s's counter at line `fetch_line` (1 = taken). It is registered, so it appears one cycle after `fetch_line` is sampled.
- R3: A valid update with `upd_taken`=1 raises its counter by one. The counter saturates at strongly-taken (11), so after any number of taken updates a single not-taken update still leaves the prediction taken.
- R4: A valid update with `upd_taken`=0 lowers its counter by one. The counter saturates at strongly-not-taken (00), so after any number of not-taken updates, two taken updates are needed before the entry predicts taken.
- R5: An update touches only one counter. That counter sits in slot `upd_pc[1:0]` (address bits [3:2]) at line `upd_pc[IDX_W+1:2]`. Every other slot and line is left unchanged.
- R6: All four slots of a line are predicted in the same cycle, each from its own independent counter.
- R7: If an update and a lookup address the same counter in the same cycle, the lookup returns the value from before the update.
- R8: While `upd_valid` is low, `upd_pc` and `upd_taken` have no effect on any counter.
- R9: With no update, repeated lookups of the same line return the same predictions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_line | input | IDX_W | Fetch-group line index (address bits above the slot field) |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | log2(SLOTS)+IDX_W | Resolved branch address bits: slot field low, line index above |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| pred_taken | output | SLOTS | Per-slot taken prediction, one cycle after lookup |

## Verification
The assertions check four properties on every cycle:
- An update enables exactly one bank, and no bank when the update is idle.
- Predictions are cleared after reset.
- For a held line, a taken update can never turn a prediction off, and a not-taken update can never turn one on.
- With no update, the predictions stay steady.

Only the bench scenarios can show the exact counter values: the saturation depth at both ends, the pre-update value returned on a same-cycle collision, and the fact that each slot keeps its own independent state. To do this, the bench compares every lookup against a reference counter table that it derives from the requirements.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WEAK_NT;

    // One saturating step toward the resolved direction.
    function automatic ctr_e ctr_step(ctr_e cur, logic taken);
        ctr_e nxt;
        if (taken) begin
            nxt = (cur == CTR_STRONG_T) ? CTR_STRONG_T : ctr_e'(cur + 2'd1);
        end else begin
            nxt = (cur == CTR_STRONG_NT) ? CTR_STRONG_NT : ctr_e'(cur - 2'd1);
        end
        return nxt;
    endfunction

    function automatic logic ctr_dir(ctr_e cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_update_route.sv
module bp_update_route #(
    parameter int SLOTS  = 4,
    parameter int SLOT_W = 2
) (
    input  logic              upd_valid,
    input  logic [SLOT_W-1:0] upd_slot,
    output logic [SLOTS-1:0]  bank_we
);
    always_comb begin
        bank_we = '0;
        if (upd_valid) begin
            bank_we[upd_slot] = 1'b1;
        end
    end
endmodule

// File: rtl/bp_counter_bank.sv
module bp_counter_bank
    import bp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_dir,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    ctr_e ctr_q [DEPTH];

    // Read and write share the edge; the read sees the pre-update value.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_RESET;
            end
            rd_dir <= 1'b0;
        end else begin
            rd_dir <= ctr_dir(ctr_q[rd_idx]);
            if (wr_en) begin
                ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
            end
        end
    end
endmodule

// File: rtl/bp_slot_predictor.sv
module bp_slot_predictor
    import bp_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int IDX_W = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [IDX_W-1:0]              fetch_line,
    input  logic                          upd_valid,
    input  logic [$clog2(SLOTS)+IDX_W-1:0] upd_pc,
    input  logic                          upd_taken,
    output logic [SLOTS-1:0]              pred_taken
);
    localparam int SLOT_W = $clog2(SLOTS);

    logic [SLOT_W-1:0] upd_slot;
    logic [IDX_W-1:0]  upd_line;
    logic [SLOTS-1:0]  bank_we;

    assign upd_slot = upd_pc[SLOT_W-1:0];
    assign upd_line = upd_pc[SLOT_W +: IDX_W];

    bp_update_route #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) i_route (
        .upd_valid (upd_valid),
        .upd_slot  (upd_slot),
        .bank_we   (bank_we)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_bank
        bp_counter_bank #(
            .IDX_W (IDX_W)
        ) i_bank (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (fetch_line),
            .rd_dir   (pred_taken[s]),
            .wr_en    (bank_we[s]),
            .wr_idx   (upd_line),
            .wr_taken (upd_taken)
        );
    end
endmodule

// File: rtl/bp_slot_predictor_chk.sv
module bp_slot_predictor_chk #(
    parameter int SLOTS = 4,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] fetch_line,
    input logic             upd_valid,
    input logic             upd_taken,
    input logic [SLOTS-1:0] bank_we,
    input logic [SLOTS-1:0] pred_taken
);
    // R1: predictions are cleared on the cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> pred_taken == '0);

    // R5: a valid update writes exactly one bank
    a_r5_single_bank: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> $countones(bank_we) == 1);

    // R8: an idle update port writes nothing
    a_r8_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |-> bank_we == '0);

    // R3: a taken update never turns a held line's prediction off
    a_r3_taken_no_fall: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid && upd_taken) && fetch_line == $past(fetch_line))
        |=> (($past(pred_taken) & ~pred_taken) == '0));

    // R4: a not-taken update never turns a held line's prediction on
    a_r4_not_taken_no_rise: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_valid && !upd_taken) && fetch_line == $past(fetch_line))
        |=> ((~$past(pred_taken) & pred_taken) == '0));

    // R9: no update and same line gives steady predictions
    a_r9_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(upd_valid) && fetch_line == $past(fetch_line))
        |=> $stable(pred_taken));
endmodule

bind bp_slot_predictor bp_slot_predictor_chk #(
    .SLOTS (SLOTS),
    .IDX_W (IDX_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_line (fetch_line),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .bank_we    (bank_we),
    .pred_taken (pred_taken)
);

// File: tb/test_bp_slot_predictor.sv
`timescale 1ns/1ps
module test_bp_slot_predictor;
    localparam int SLOTS = 4;
    localparam int IDX_W = 6;
    localparam int LINES = 1 << IDX_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] fetch_line = '0;
    logic       upd_valid = 1'b0;
    logic [7:0] upd_pc = '0;
    logic       upd_taken = 1'b0;
    logic [3:0] pred_taken;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int         model [SLOTS][LINES];
    logic [3:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    bp_slot_predictor #(.SLOTS(SLOTS), .IDX_W(IDX_W)) i_bp_slot_predictor (
        .clk(clk), .rst(rst), .fetch_line(fetch_line), .upd_valid(upd_valid),
        .upd_pc(upd_pc), .upd_taken(upd_taken), .pred_taken(pred_taken)
    );

    // Driver: apply one cycle of stimulus, queue the expected lookup result
    // (taken from the model before the update, R7), then advance the model.
    task automatic step(input int line, input bit uv, input int slot,
                        input int uline, input bit ut, input string tag);
        logic [3:0] e;
        @(negedge clk);
        fetch_line = 6'(line);
        upd_valid  = uv;
        upd_pc     = {6'(uline), 2'(slot)};
        upd_taken  = ut;
        for (int s = 0; s < SLOTS; s++) e[s] = (model[s][line] >= 2);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (uv) begin
            if (ut && model[slot][uline] < 3) model[slot][uline]++;
            if (!ut && model[slot][uline] > 0) model[slot][uline]--;
        end
    endtask

    // Monitor: compare one result after each edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (pred_taken !== e) begin
                fails++;
                $display("FAIL %s: pred_taken=%b expected=%b", t, pred_taken, e);
            end
        end
    end

    initial begin
        for (int s = 0; s < SLOTS; s++)
            for (int l = 0; l < LINES; l++) model[s][l] = 1;
        repeat (4) @(negedge clk);
        tests++;
        if (pred_taken !== 4'b0000) begin
            fails++;
            $display("FAIL R1: pred_taken=%b expected=0000 in reset", pred_taken);
        end
        rst = 1'b0;
        // R1: reset state is weakly not taken everywhere
        step(0, 0, 0, 0, 0, "R1");
        step(63, 0, 0, 0, 0, "R1");
        // R2/R1: one taken update flips slot 2 of line 3
        step(3, 1, 2, 3, 1, "R2");
        step(3, 0, 0, 0, 0, "R2");
        // R3: saturate high, one not-taken keeps it taken
        for (int i = 0; i < 4; i++) step(3, 1, 2, 3, 1, "R3");
        step(3, 1, 2, 3, 0, "R3");
        step(3, 0, 0, 0, 0, "R3");
        // R4: saturate low, two taken needed
        for (int i = 0; i < 5; i++) step(9, 1, 0, 9, 0, "R4");
        step(9, 1, 0, 9, 1, "R4");
        step(9, 0, 0, 0, 0, "R4");
        step(9, 1, 0, 9, 1, "R4");
        step(9, 0, 0, 0, 0, "R4");
        // R6: slots of one line hold independent counters
        step(20, 1, 1, 20, 1, "R6");
        step(20, 1, 3, 20, 1, "R6");
        step(20, 1, 3, 20, 1, "R6");
        step(20, 1, 3, 20, 0, "R6");
        step(20, 0, 0, 0, 0, "R6");
        // R5: neighbouring line and other slots untouched
        step(21, 0, 0, 0, 0, "R5");
        step(3, 0, 0, 0, 0, "R5");
        // R7: same-cycle update and lookup returns old value
        step(30, 1, 0, 30, 1, "R7");
        step(30, 1, 0, 30, 0, "R7");
        step(30, 0, 0, 0, 0, "R7");
        // R8: idle update port has no effect
        for (int i = 0; i < 3; i++) step(40, 0, 1, 40, 1, "R8");
        step(40, 0, 0, 0, 0, "R8");
        // R9: steady lookups without updates
        for (int i = 0; i < 4; i++) step(20, 0, 0, 0, 0, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule